// File: doc/BRIEF.md
# Cycle-Bit Ring Entry Fetcher

This block drains a ring of 16-byte work entries that a producer fills in shared memory. The ring is made of segments, and a jump entry at the end of each segment points to the next one. The block does not compare producer and consumer pointers to decide who owns an entry. It reads the entry at its dequeue pointer and checks the entry's ownership bit against its own expected-phase flag. A match means the entry is new and may be consumed. A mismatch means the producer has not reached this slot yet, so the block parks and waits for the next doorbell pulse.

Entries that match and are not jumps go out unchanged on a valid/ready stream, with an end-of-descriptor flag. Jump entries are handled inside the block: they reload the dequeue pointer and may invert the expected-phase flag. This is how the producer's phase can flip once per lap around the ring. Memory is read through a simple port with a fixed one-cycle read latency. Back-pressure rules: once `out_valid` rises, the word and its flag stay frozen until `out_ready` is seen high on a clock edge. No further memory read is issued while an entry is waiting downstream.

Top module: `trb_ring_reader`

## Requirements
- R1: After reset `out_valid` and `mem_rd_en` are 0 and `deq_ptr` is 0.
- R2: Entry layout. Dword k occupies bits 32k+31:32k. In dword 3, bit 0 is the ownership bit, bit 1 is the phase-invert flag (jump entries only), bit 4 is the continue bit, and bits 15:10 are the kind, where kind 6 marks a jump. A jump's target is dword 0 with its low 4 bits forced to zero.
- R3: A `ring_init` pulse while the block is idle loads `deq_ptr` from `start_ptr` and the expected-phase flag from `start_cycle`. The new pointer is visible on the next cycle.
- R4: A doorbell sampled while idle raises `mem_rd_en` on the next cycle, with `mem_rd_addr` equal to `deq_ptr`. Read data is taken one cycle after `mem_rd_en`.
- R5: An entry whose ownership bit equals the expected phase and whose kind is not a jump is presented unchanged on `out_trb`. `out_td_end` is the inverse of its continue bit.
- R6: While `out_valid` is high and `out_ready` is low, `out_trb`, `out_td_end` and `deq_ptr` hold. A handshake advances `deq_ptr` by 16.
- R7: A jump entry is never presented downstream. It sets `deq_ptr` to the jump target, and if its phase-invert flag is set it inverts the expected phase.
- R8: An entry whose ownership bit differs from the expected phase produces no output. `deq_ptr` stays on that entry and the block idles until the next doorbell.
- R9: A doorbell that arrives while the block is busy is remembered. On the next mismatch the block re-reads the same entry once instead of idling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_init | input | 1 | Load start pointer and phase (idle only) |
| start_ptr | input | ADDR_W | Byte address of first entry |
| start_cycle | input | 1 | Initial expected phase |
| doorbell | input | 1 | Work-available pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Byte address of entry being read |
| mem_rd_data | input | 128 | Entry returned one cycle after the strobe |
| out_valid | output | 1 | Entry available downstream |
| out_ready | input | 1 | Downstream accepts the entry |
| out_trb | output | 128 | Entry contents |
| out_td_end | output | 1 | Entry closes its descriptor |
| deq_ptr | output | ADDR_W | Current dequeue byte address |

## Verification
A wrong expected-phase flag shows up as soon as the first entry after a jump is read. A matching entry is then dropped, with no `out_valid`, or a stale slot is emitted in the cycle after the read returns. A bad pointer update shows on `deq_ptr` one cycle after the handshake or jump, and the next read address repeats it. A lost pending doorbell shows only as a missing re-read strobe a few cycles after the mismatch, so the bench counts read strobes across each phase.

// File: rtl/trb_ring_pkg.sv
package trb_ring_pkg;
  localparam int TRB_W      = 128;
  localparam int DW3_LSB    = 96;
  localparam int CYC_BIT    = DW3_LSB + 0;
  localparam int TGL_BIT    = DW3_LSB + 1;
  localparam int CHN_BIT    = DW3_LSB + 4;
  localparam int KIND_LSB   = DW3_LSB + 10;
  localparam int KIND_W     = 6;
  localparam logic [KIND_W-1:0] KIND_JUMP = 6'd6;
  localparam int ENTRY_BYTES = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2,
    ST_EMIT  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/trb_field_decode.sv
module trb_field_decode
  import trb_ring_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [TRB_W-1:0]  trb,
  input  logic              phase,
  output logic              owned,
  output logic              is_jump,
  output logic              invert,
  output logic              td_end,
  output logic [ADDR_W-1:0] jump_ptr
);
  localparam int LOW_W = $clog2(ENTRY_BYTES);

  logic [KIND_W-1:0] kind;

  always_comb begin
    kind     = trb[KIND_LSB +: KIND_W];
    owned    = (trb[CYC_BIT] == phase);
    is_jump  = (kind == KIND_JUMP);
    invert   = is_jump & trb[TGL_BIT];
    td_end   = ~trb[CHN_BIT];
    jump_ptr = {trb[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/ring_cursor.sv
module ring_cursor
  import trb_ring_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_ptr,
  input  logic              load_phase,
  input  logic              advance,
  input  logic              jump,
  input  logic [ADDR_W-1:0] jump_ptr,
  input  logic              flip,
  output logic [ADDR_W-1:0] ptr,
  output logic              phase
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ENTRY_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      phase <= 1'b0;
    end else if (load) begin
      ptr   <= load_ptr;
      phase <= load_phase;
    end else if (jump) begin
      ptr   <= jump_ptr;
      phase <= phase ^ flip;
    end else if (advance) begin
      ptr   <= ptr + STEP;
    end
  end
endmodule

// File: rtl/trb_hold.sv
module trb_hold
  import trb_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [TRB_W-1:0] din,
  input  logic             din_end,
  input  logic             ready,
  output logic             valid,
  output logic [TRB_W-1:0] dout,
  output logic             dout_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      dout     <= '0;
      dout_end <= 1'b0;
    end else if (capture) begin
      valid    <= 1'b1;
      dout     <= din;
      dout_end <= din_end;
    end else if (valid && ready) begin
      valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/trb_ring_reader.sv
module trb_ring_reader
  import trb_ring_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_init,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic              start_cycle,
  input  logic              doorbell,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [TRB_W-1:0]  mem_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TRB_W-1:0]  out_trb,
  output logic              out_td_end,
  output logic [ADDR_W-1:0] deq_ptr
);
  rd_state_e         state_q, state_d;
  logic              pend_q, pend_d;
  logic              ccs_q;
  logic              owned, is_jump, invert, td_end;
  logic [ADDR_W-1:0] jump_ptr;
  logic              do_load, do_adv, do_jump, do_cap;

  trb_field_decode #(.ADDR_W(ADDR_W)) u_dec (
    .trb      (mem_rd_data),
    .phase    (ccs_q),
    .owned    (owned),
    .is_jump  (is_jump),
    .invert   (invert),
    .td_end   (td_end),
    .jump_ptr (jump_ptr)
  );

  ring_cursor #(.ADDR_W(ADDR_W)) u_cur (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (do_load),
    .load_ptr   (start_ptr),
    .load_phase (start_cycle),
    .advance    (do_adv),
    .jump       (do_jump),
    .jump_ptr   (jump_ptr),
    .flip       (invert),
    .ptr        (deq_ptr),
    .phase      (ccs_q)
  );

  trb_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (do_cap),
    .din      (mem_rd_data),
    .din_end  (td_end),
    .ready    (out_ready),
    .valid    (out_valid),
    .dout     (out_trb),
    .dout_end (out_td_end)
  );

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    do_load   = 1'b0;
    do_adv    = 1'b0;
    do_jump   = 1'b0;
    do_cap    = 1'b0;
    mem_rd_en = 1'b0;
    if (state_q != ST_IDLE && doorbell) pend_d = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        do_load = ring_init;
        if (doorbell) begin
          state_d = ST_FETCH;
          pend_d  = 1'b0;
        end
      end
      ST_FETCH: begin
        mem_rd_en = 1'b1;
        state_d   = ST_RESP;
      end
      ST_RESP: begin
        if (!owned) begin
          if (pend_q || doorbell) begin
            state_d = ST_FETCH;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (is_jump) begin
          do_jump = 1'b1;
          state_d = ST_FETCH;
        end else begin
          do_cap  = 1'b1;
          state_d = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (out_valid && out_ready) begin
          do_adv  = 1'b1;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_rd_addr = deq_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/trb_ring_reader_chk.sv
module trb_ring_reader_chk
  import trb_ring_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TRB_W-1:0]  out_trb,
  input logic              out_td_end,
  input logic [ADDR_W-1:0] deq_ptr,
  input logic              ccs
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ENTRY_BYTES);

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_trb) && $stable(out_td_end) && $stable(deq_ptr))); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (deq_ptr == $past(deq_ptr) + STEP)); // R6
  AST_NO_JUMP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_trb[KIND_LSB +: KIND_W] != KIND_JUMP)); // R7
  AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_trb[CYC_BIT] == ccs)); // R5
  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_td_end == !out_trb[CHN_BIT])); // R5
  AST_NO_READ_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !out_valid); // R4
endmodule

bind trb_ring_reader trb_ring_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd_en  (mem_rd_en),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_trb    (out_trb),
  .out_td_end (out_td_end),
  .deq_ptr    (deq_ptr),
  .ccs        (ccs_q)
);

// File: tb/trb_ring_reader_test.sv
module trb_ring_reader_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ring_init = 1'b0;
  logic [AW-1:0] start_ptr = '0;
  logic          start_cycle = 1'b0;
  logic          doorbell = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [127:0]  mem_rd_data;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [127:0]  out_trb;
  logic          out_td_end;
  logic [AW-1:0] deq_ptr;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  logic [127:0] mem [32];

  always #5 clk = ~clk;

  trb_ring_reader #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .start_ptr(start_ptr),
    .start_cycle(start_cycle), .doorbell(doorbell), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_trb(out_trb), .out_td_end(out_td_end), .deq_ptr(deq_ptr)
  );

  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr[8:4]];
      rd_cnt      <= rd_cnt + 1;
    end
  end

  // entry builder following the R2 layout
  function automatic logic [127:0] mk(input logic [31:0] dw0, input logic chn,
                                      input logic cyc, input logic [5:0] kind, input logic tgl);
    logic [31:0] dw3;
    dw3 = {16'd0, kind, 5'd0, chn, 2'd0, tgl, cyc};
    return {dw3, 32'h0, 32'h0, dw0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ring();
    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (out_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // {tag, td_end, stall, expected deq_ptr}
  localparam int NV = 5;
  localparam logic [50:0] VEC [NV] = '{
    {32'hA000_0001, 1'b0, 2'd0, 16'h0000},
    {32'hA000_0002, 1'b1, 2'd2, 16'h0010},
    {32'hA000_0003, 1'b1, 2'd1, 16'h0020},
    {32'hB000_0001, 1'b0, 2'd3, 16'h0100},
    {32'hB000_0002, 1'b1, 2'd0, 16'h0110}
  };

  initial begin
    bit got;
    int base;
    logic [127:0] snap;
    for (int i = 0; i < 32; i++) mem[i] = mk(32'h0, 1'b0, 1'b1, 6'd1, 1'b0);
    mem[0]  = mk(32'hA000_0001, 1'b1, 1'b1, 6'd1, 1'b0);
    mem[1]  = mk(32'hA000_0002, 1'b0, 1'b1, 6'd1, 1'b0);
    mem[2]  = mk(32'hA000_0003, 1'b0, 1'b1, 6'd1, 1'b0);
    mem[3]  = mk(32'h0000_0107, 1'b0, 1'b1, 6'd6, 1'b0); // jump, low bits dropped
    mem[16] = mk(32'hB000_0001, 1'b1, 1'b1, 6'd1, 1'b0);
    mem[17] = mk(32'hB000_0002, 1'b0, 1'b1, 6'd1, 1'b0);
    mem[18] = mk(32'h0000_0000, 1'b0, 1'b1, 6'd6, 1'b1); // jump back, invert

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", 128'(out_valid), 0);
    chk(mem_rd_en == 1'b0, "R1 rd_en", 128'(mem_rd_en), 0);
    chk(deq_ptr == '0, "R1 ptr", 128'(deq_ptr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    start_ptr = 16'h0000; start_cycle = 1'b1; ring_init = 1'b1;
    @(negedge clk);
    ring_init = 1'b0;
    chk(deq_ptr == 16'h0000, "R3 init ptr", 128'(deq_ptr), 0);

    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
    chk(mem_rd_en == 1'b1, "R4 strobe", 128'(mem_rd_en), 1);
    chk(mem_rd_addr == deq_ptr, "R4 addr", 128'(mem_rd_addr), 128'(deq_ptr));

    for (int v = 0; v < NV; v++) begin
      wait_valid(got);
      chk(got, "R5 valid", 128'(got), 1);
      chk(out_trb == mem[VEC[v][8:4] | 5'(VEC[v][15:8] == 8'h01 ? 16 : 0)], "R5 data",
          out_trb, mem[VEC[v][8:4] | 5'(VEC[v][15:8] == 8'h01 ? 16 : 0)]);
      chk(out_trb[31:0] == VEC[v][50:19], "R7 order", 128'(out_trb[31:0]), 128'(VEC[v][50:19]));
      chk(out_td_end == VEC[v][18], "R5 td_end", 128'(out_td_end), 128'(VEC[v][18]));
      chk(deq_ptr == VEC[v][15:0], "R6 ptr", 128'(deq_ptr), 128'(VEC[v][15:0]));
      snap = out_trb;
      for (int s = 0; s < int'(VEC[v][17:16]); s++) begin
        @(negedge clk);
        chk(out_valid && out_trb == snap && deq_ptr == VEC[v][15:0], "R6 hold", out_trb, snap);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end

    // after the inverting jump, slot 0 still carries the old phase: mismatch stop
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b0, "R8 no output", 128'(out_valid), 0);
    chk(deq_ptr == 16'h0000, "R7 jump target", 128'(deq_ptr), 0);

    base = rd_cnt;
    ring();
    repeat (8) @(negedge clk);
    chk(rd_cnt - base == 1, "R8 single read", 128'(rd_cnt - base), 1);
    chk(out_valid == 1'b0 && deq_ptr == 16'h0000, "R8 parked", 128'(deq_ptr), 0);

    // new-phase entry accepted (proves inversion); doorbell while held is remembered
    mem[0] = mk(32'hC000_0001, 1'b0, 1'b0, 6'd1, 1'b0);
    base = rd_cnt;
    ring();
    wait_valid(got);
    chk(got && out_trb[31:0] == 32'hC000_0001, "R7 phase inverted", 128'(out_trb[31:0]), 128'(32'hC000_0001));
    ring();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    repeat (10) @(negedge clk);
    chk(rd_cnt - base == 3, "R9 refetch", 128'(rd_cnt - base), 3);
    chk(deq_ptr == 16'h0010 && !out_valid, "R9 parked", 128'(deq_ptr), 128'(16'h0010));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule